// File: doc/BRIEF.md
# Scanline Pixel Output Stage

This block sits at the end of a background pixel pipeline. On each dot it takes one 2-bit colour index from an upstream pixel FIFO and looks it up in an 8-bit palette register to get a 2-bit shade. It then writes that shade into a framebuffer write port at the address `line * 160 + column`. A signed horizontal position, loaded negative at the start of every line, decides which popped pixels are visible. Pixels that belong to the fine-scroll lead-in or lie off screen are consumed and thrown away, so the fetcher upstream always works on whole 8-pixel tiles.

The controller is a small state machine. `ST_IDLE` is the state after reset. `ST_SCAN` is entered by a `line_start` pulse from any state. `ST_SCAN` moves to `ST_DONE` on the dot that advances the position to the line width. `ST_DONE` holds until the next `line_start`, which moves it to `ST_SCAN` again.

Two dots before the end of the line, a one-cycle `blank_start` pulse tells the surrounding display logic to do three things: clear its mode field, release video and object memory, and start any pending blank-triggered DMA. The `dma_start` output gives that last side effect as its own pulse. A `render_off` input lets the position run freely while discarding pixels.

Top module: `scanpix_out`

## Requirements
- R1: A `line_start` pulse moves the controller to `ST_SCAN` and loads the position with `-(fine_scroll) - 8`. No FIFO entry is popped on the `line_start` dot.
- R2: In `ST_SCAN` with `render_off` low and `pause` low, one entry is popped (`fifo_pop` high) on every dot where `fifo_valid` is high, and the position advances by one. When `fifo_valid` is low, nothing is popped and the position holds.
- R3: While `pause` is high and `render_off` is low, no entry is popped, no framebuffer write is produced and the position holds.
- R4: The written shade is `palette[2*i+1 : 2*i]`, where `i` is the popped 2-bit colour index.
- R5: A pixel popped at a negative position is dropped without a write. A pixel popped at position 0..159 gives a one-cycle `fb_we` on the clock edge that consumes it, with `fb_addr = line_num*160 + position`. The result is therefore visible in the cycle after the popping dot, and writes arrive in column order 0..159.
- R6: When the position reaches 160, the controller enters `ST_DONE` and `line_done` goes high. `line_done` stays high and nothing more is popped until the next `line_start`.
- R7: The dot that advances the position from 158 to 159 gives exactly one single-cycle `blank_start` pulse per line. This is the same cycle as the write of column 158. `dma_start` pulses with it if `dma_armed` was high on that dot and stays low otherwise.
- R8: With `render_off` high in `ST_SCAN`, the position advances on every dot regardless of `pause` or `fifo_valid`. An entry is popped only when `fifo_valid` is high and `pause` is low, and no framebuffer write is made. The line therefore ends exactly `168 + fine_scroll` dots after `line_start`.
- R9: A synchronous reset puts the controller in `ST_IDLE` and clears the position, `line_done`, `fb_we`, `blank_start` and `dma_start`. `fifo_pop` stays low until the next `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | One-dot pulse starting a new scanline |
| line_num | input | 8 | Current line number, used for the write address |
| fine_scroll | input | 3 | Horizontal fine scroll (scroll X mod 8) |
| render_off | input | 1 | Run the position without producing pixels |
| pause | input | 1 | Hold popping and pixel output |
| dma_armed | input | 1 | A blank-triggered DMA is pending |
| fifo_valid | input | 1 | The pixel FIFO holds at least one entry |
| fifo_data | input | 2 | Colour index at the FIFO head |
| fifo_pop | output | 1 | Consume the FIFO head this dot |
| palette | input | 8 | Four 2-bit shades, entry i in bits [2i+1:2i] |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_addr | output | 15 | Framebuffer address, line*160 + column |
| fb_shade | output | 2 | Shade to write |
| line_done | output | 1 | The visible line has ended |
| blank_start | output | 1 | Pulse: enter horizontal blanking |
| dma_start | output | 1 | Pulse: start the pending blank DMA |

## Verification
The bench sweeps every fine-scroll value against several palettes and line numbers, with FIFO gaps and pause dots mixed in. Every write's address and shade is computed from the pop count alone. A design with an off-by-one in the load value would shift every address and colour by one column. A stage that advanced during a stall or pause would skip pixels or write more or fewer than 160 of them. The bench also checks the blanking pulse exactly at the column-158 write: a comparison against 159 or 160 would move it one dot late or lose it entirely. Runs with rendering off check the fixed line length and that no writes are made. A mid-line reset must leave the stage idle and quiet.

// File: rtl/scanpix_pkg.sv
package scanpix_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_e;

endpackage

// File: rtl/scanpix_palette_map.sv
module scanpix_palette_map #(
    parameter int CIDX_W  = 2,
    parameter int SHADE_W = 2,
    localparam int ENTRIES = 2 ** CIDX_W,
    localparam int PAL_W   = SHADE_W * ENTRIES
) (
    input  logic [PAL_W-1:0]   palette,
    input  logic [CIDX_W-1:0]  idx,
    output logic [SHADE_W-1:0] shade
);

    logic [SHADE_W-1:0] entry [ENTRIES];

    // One slice per colour index; entry e lives at bits [e*SHADE_W +: SHADE_W]
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign entry[e] = palette[e*SHADE_W +: SHADE_W];
    end

    assign shade = entry[idx];

endmodule

// File: rtl/scanpix_fb_writer.sv
module scanpix_fb_writer #(
    parameter int WIDTH   = 160,
    parameter int LINES   = 144,
    parameter int SHADE_W = 2,
    localparam int LINE_W = $clog2(LINES),
    localparam int COL_W  = $clog2(WIDTH),
    localparam int TOTAL  = WIDTH * LINES,
    localparam int ADDR_W = $clog2(TOTAL)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_req,
    input  logic [LINE_W-1:0]  line_num,
    input  logic [COL_W-1:0]   col,
    input  logic [SHADE_W-1:0] shade,
    output logic               fb_we,
    output logic [ADDR_W-1:0]  fb_addr,
    output logic [SHADE_W-1:0] fb_shade
);

    logic [ADDR_W-1:0] addr_d;

    assign addr_d = ADDR_W'(line_num) * ADDR_W'(WIDTH) + ADDR_W'(col);

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_we    <= 1'b0;
            fb_addr  <= '0;
            fb_shade <= '0;
        end else begin
            fb_we <= wr_req;
            if (wr_req) begin
                fb_addr  <= addr_d;
                fb_shade <= shade;
            end
        end
    end

    // R5: every write lands inside the frame
    p_addr_range_r5: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (fb_addr < ADDR_W'(TOTAL)));

    // R5: a strobe is a single cycle unless fed back to back
    p_we_follows_req_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> !fb_we);

endmodule

// File: rtl/scanpix_pos_ctrl.sv
module scanpix_pos_ctrl
    import scanpix_pkg::*;
#(
    parameter int WIDTH  = 160,
    parameter int FINE_W = 3,
    localparam int COL_W = $clog2(WIDTH),
    localparam int POS_W = $clog2(WIDTH + 2 * (2 ** FINE_W)) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [FINE_W-1:0] fine,
    input  logic              render_off,
    input  logic              pause,
    input  logic              fifo_valid,
    input  logic              dma_armed,
    output logic              fifo_pop,
    output logic              wr_req,
    output logic [COL_W-1:0]  col,
    output logic              line_done,
    output logic              blank_start,
    output logic              dma_start
);

    localparam logic signed [POS_W-1:0] POS_LEAD = POS_W'(2 ** FINE_W);
    localparam logic signed [POS_W-1:0] POS_LAST = POS_W'(WIDTH - 1);
    localparam logic signed [POS_W-1:0] POS_TRIG = POS_W'(WIDTH - 2);
    localparam logic signed [POS_W-1:0] POS_END  = POS_W'(WIDTH);

    scan_state_e              state_q, state_d;
    logic signed [POS_W-1:0]  pos_q;
    logic signed [POS_W-1:0]  pos_load;
    logic                     scanning;
    logic                     advance;
    logic                     in_view;

    assign pos_load = -POS_LEAD - $signed(POS_W'(fine));
    assign scanning = (state_q == ST_SCAN) && !line_start;
    assign fifo_pop = scanning && !pause && fifo_valid;
    assign advance  = scanning && (render_off || fifo_pop);
    assign in_view  = !pos_q[POS_W-1] && (pos_q < POS_END);
    assign wr_req   = fifo_pop && !render_off && in_view;
    assign col      = pos_q[COL_W-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (line_start) state_d = ST_SCAN;
            ST_SCAN: begin
                if (line_start)
                    state_d = ST_SCAN;
                else if (advance && pos_q == POS_LAST)
                    state_d = ST_DONE;
            end
            ST_DONE: if (line_start) state_d = ST_SCAN;
            default: state_d = ST_IDLE;
        endcase
    end

    // Horizontal position
    always_ff @(posedge clk) begin
        if (rst)             pos_q <= '0;
        else if (line_start) pos_q <= pos_load;
        else if (advance)    pos_q <= pos_q + POS_W'(1);
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            line_done   <= 1'b0;
            blank_start <= 1'b0;
            dma_start   <= 1'b0;
        end else begin
            line_done   <= (state_d == ST_DONE);
            blank_start <= advance && (pos_q == POS_TRIG);
            dma_start   <= advance && (pos_q == POS_TRIG) && dma_armed;
        end
    end

    // R1: the load value follows the fine scroll
    p_load_r1: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (pos_q == -POS_LEAD - $signed(POS_W'($past(fine)))));

    // R3: paused with rendering on, the position does not move
    p_hold_pause_r3: assert property (@(posedge clk) disable iff (rst)
        (scanning && pause && !render_off) |=> $stable(pos_q));

    // R6: the end flag means the position reached the line width
    p_done_pos_r6: assert property (@(posedge clk) disable iff (rst)
        line_done |-> (pos_q == POS_END));

    // R6: nothing is consumed outside a scan
    p_no_pop_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_SCAN) |-> !fifo_pop);

    // R7: the blanking pulse never lasts two cycles
    p_blank_single_r7: assert property (@(posedge clk) disable iff (rst)
        blank_start |=> !blank_start);

    // R7: the DMA kick only comes with the blanking pulse
    p_dma_with_blank_r7: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> blank_start);

    // R8: with rendering off, each scanning dot advances
    p_free_run_r8: assert property (@(posedge clk) disable iff (rst)
        (scanning && render_off) |=> (pos_q == $past(pos_q) + POS_W'(1)));

endmodule

// File: rtl/scanpix_out.sv
module scanpix_out #(
    parameter int WIDTH   = 160,
    parameter int LINES   = 144,
    parameter int FINE_W  = 3,
    parameter int CIDX_W  = 2,
    parameter int SHADE_W = 2,
    localparam int LINE_W = $clog2(LINES),
    localparam int COL_W  = $clog2(WIDTH),
    localparam int ADDR_W = $clog2(WIDTH * LINES),
    localparam int PAL_W  = SHADE_W * (2 ** CIDX_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic [LINE_W-1:0]  line_num,
    input  logic [FINE_W-1:0]  fine_scroll,
    input  logic               render_off,
    input  logic               pause,
    input  logic               dma_armed,
    input  logic               fifo_valid,
    input  logic [CIDX_W-1:0]  fifo_data,
    output logic               fifo_pop,
    input  logic [PAL_W-1:0]   palette,
    output logic               fb_we,
    output logic [ADDR_W-1:0]  fb_addr,
    output logic [SHADE_W-1:0] fb_shade,
    output logic               line_done,
    output logic               blank_start,
    output logic               dma_start
);

    logic               wr_req;
    logic [COL_W-1:0]   col;
    logic [SHADE_W-1:0] shade;

    scanpix_pos_ctrl #(
        .WIDTH  (WIDTH),
        .FINE_W (FINE_W)
    ) i_ctrl (
        .clk         (clk),
        .rst         (rst),
        .line_start  (line_start),
        .fine        (fine_scroll),
        .render_off  (render_off),
        .pause       (pause),
        .fifo_valid  (fifo_valid),
        .dma_armed   (dma_armed),
        .fifo_pop    (fifo_pop),
        .wr_req      (wr_req),
        .col         (col),
        .line_done   (line_done),
        .blank_start (blank_start),
        .dma_start   (dma_start)
    );

    scanpix_palette_map #(
        .CIDX_W  (CIDX_W),
        .SHADE_W (SHADE_W)
    ) i_map (
        .palette (palette),
        .idx     (fifo_data),
        .shade   (shade)
    );

    scanpix_fb_writer #(
        .WIDTH   (WIDTH),
        .LINES   (LINES),
        .SHADE_W (SHADE_W)
    ) i_wr (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .line_num (line_num),
        .col      (col),
        .shade    (shade),
        .fb_we    (fb_we),
        .fb_addr  (fb_addr),
        .fb_shade (fb_shade)
    );

    // R3: a pause with rendering on stops the FIFO
    p_pause_no_pop_r3: assert property (@(posedge clk) disable iff (rst)
        (pause && !render_off) |-> !fifo_pop);

    // R8: rendering off never writes the framebuffer
    p_off_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        render_off |=> !fb_we);

endmodule

// File: tb/test_scanpix_out.sv
module test_scanpix_out;

    localparam int WIDTH = 160;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start = 1'b0;
    logic [7:0]  line_num = '0;
    logic [2:0]  fine_scroll = '0;
    logic        render_off = 1'b0;
    logic        pause = 1'b0;
    logic        dma_armed = 1'b0;
    logic        fifo_valid = 1'b0;
    logic [1:0]  fifo_data;
    logic        fifo_pop;
    logic [7:0]  palette = 8'hE4;
    logic        fb_we;
    logic [14:0] fb_addr;
    logic [1:0]  fb_shade;
    logic        line_done;
    logic        blank_start;
    logic        dma_start;

    int checks = 0;
    int fails = 0;
    bit ended = 1'b0;
    int npop = 0;
    int cur_line = 0;

    always #5 clk = ~clk;

    function automatic int dval(int n, int ln);
        return ((n ^ (n >> 2)) + ln) & 3;
    endfunction

    assign fifo_data = 2'(dval(npop, cur_line));

    scanpix_out i_scanpix_out (
        .clk(clk), .rst(rst), .line_start(line_start), .line_num(line_num),
        .fine_scroll(fine_scroll), .render_off(render_off), .pause(pause),
        .dma_armed(dma_armed), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .palette(palette), .fb_we(fb_we), .fb_addr(fb_addr),
        .fb_shade(fb_shade), .line_done(line_done), .blank_start(blank_start),
        .dma_start(dma_start)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_line(int fs, int ln, int pal, bit roff, bit arm,
                            bit pmode, bit vmode, int hold_pause);
        int wr = 0;
        int blanks = 0;
        int pops = 0;
        int dot = 0;
        bit popped;
        bit done = 1'b0;
        @(posedge clk); #1;
        npop = 0; cur_line = ln;
        line_start = 1'b1; line_num = 8'(ln); fine_scroll = 3'(fs);
        palette = 8'(pal); render_off = roff; dma_armed = arm;
        pause = 1'b0; fifo_valid = 1'b1;
        @(negedge clk);
        popped = fifo_pop;
        chk(!fifo_pop, "R1", "pop on line_start dot", int'(fifo_pop), 0);
        while (!done && dot < 1000) begin
            @(posedge clk); #1;
            if (popped) begin npop++; pops++; end
            dot++;
            line_start = 1'b0;
            pause = (dot <= hold_pause) || (pmode && (dot % 11 == 5));
            fifo_valid = !(vmode && (dot % 7 == 3));
            @(negedge clk);
            popped = fifo_pop;
            if (pause && !roff)
                chk(!fifo_pop, "R3", "pop while paused", int'(fifo_pop), 0);
            if (!fifo_valid && !roff)
                chk(!fifo_pop, "R2", "pop while FIFO empty", int'(fifo_pop), 0);
            if (dot >= 2 && dot <= hold_pause)
                chk(!fb_we, "R3", "write while paused", int'(fb_we), 0);
            if (fb_we) begin
                if (roff) begin
                    chk(1'b0, "R8", "write with rendering off", 1, 0);
                end else begin
                    chk(int'(fb_addr) == ln * WIDTH + wr, "R5", "write address",
                        int'(fb_addr), ln * WIDTH + wr);
                    chk(int'(fb_shade) == ((pal >> (2 * dval(wr + fs + 8, ln))) & 3),
                        "R4", "shade", int'(fb_shade),
                        (pal >> (2 * dval(wr + fs + 8, ln))) & 3);
                end
                wr++;
            end
            if (blank_start) begin
                blanks++;
                if (!roff)
                    chk(fb_we && wr == WIDTH - 1, "R7", "blank pulse column", wr, WIDTH - 1);
                chk(dma_start == arm, "R7", "dma pulse", int'(dma_start), int'(arm));
            end else begin
                chk(!dma_start, "R7", "dma without blank", int'(dma_start), 0);
            end
            if (line_done) done = 1'b1;
        end
        chk(done, "R6", "line end seen", int'(done), 1);
        chk(blanks == 1, "R7", "blank pulses per line", blanks, 1);
        if (!roff) begin
            chk(wr == WIDTH, "R5", "writes per line", wr, WIDTH);
            chk(pops == WIDTH + 8 + fs, "R2", "pops per line", pops, WIDTH + 8 + fs);
        end else begin
            chk(dot == WIDTH + 8 + fs + 1, "R8", "free-run line length", dot, WIDTH + 9 + fs);
        end
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            pause = 1'b0; fifo_valid = 1'b1;
            @(negedge clk);
            chk(!fifo_pop, "R6", "pop after line end", int'(fifo_pop), 0);
            chk(line_done, "R6", "line_done held", int'(line_done), 1);
        end
    endtask

    task automatic check_reset_quiet();
        chk(!fb_we, "R9", "fb_we after reset", int'(fb_we), 0);
        chk(!line_done, "R9", "line_done after reset", int'(line_done), 0);
        chk(!blank_start, "R9", "blank_start after reset", int'(blank_start), 0);
        chk(!dma_start, "R9", "dma_start after reset", int'(dma_start), 0);
        chk(!fifo_pop, "R9", "fifo_pop after reset", int'(fifo_pop), 0);
    endtask

    initial begin
        int pals [3];
        pals[0] = 8'hE4; pals[1] = 8'h1B; pals[2] = 8'h72;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0; fifo_valid = 1'b1;
        @(negedge clk);
        check_reset_quiet();

        for (int fs = 0; fs < 8; fs++)
            for (int p = 0; p < 3; p++)
                run_line(fs, (fs * 19 + p * 5) % 144, pals[p], 1'b0, fs[0],
                         p == 1, p == 2, 0);

        run_line(3, 143, 8'hE4, 1'b0, 1'b1, 1'b0, 1'b0, 25);
        run_line(0, 10, 8'h1B, 1'b1, 1'b1, 1'b1, 1'b1, 0);
        run_line(7, 0, 8'h72, 1'b1, 1'b0, 1'b0, 1'b0, 0);

        // R9: reset in the middle of a line
        @(posedge clk); #1;
        line_start = 1'b1; render_off = 1'b0; pause = 1'b0; fifo_valid = 1'b1;
        @(posedge clk); #1;
        line_start = 1'b0;
        repeat (30) @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check_reset_quiet();
        repeat (5) begin
            @(negedge clk);
            chk(!fifo_pop, "R9", "idle after reset", int'(fifo_pop), 0);
        end
        run_line(5, 77, 8'h93, 1'b0, 1'b0, 1'b1, 1'b1, 0);

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule